// File: doc/BRIEF.md
# Banked Packed-Pixel Video Memory Window

This block gives a host bus byte and word access to a packed-pixel video memory through three apertures. Two small banked apertures each cover one page of the memory, and the page is picked by a bank selector input that belongs to that aperture. A third, flat aperture reaches every byte of the memory directly. Word accesses are little-endian and cover two consecutive bytes. Every write that lands in the memory marks an 8-byte group in a dirty bitmap and also sets a sticky summary, so that a scan-out agent can copy only the groups that changed. The agent reads a dirty entry and clears it through a dedicated port.

The bitmap has half as many entries as there are 8-byte groups. Each entry holds two flag bits: bit 0 marks a change in the lower half of the memory and bit 1 a change in the upper half. Groups at the same position in the two halves therefore share an entry but never share a flag. When the graphics enable and bit 0 of the mode byte are both set, the banked apertures switch to plane access. Byte accesses to them then do nothing, and word accesses go out on a plane port to an external plane engine. The flat aperture behaves the same in either mode.

Top module: `vram_bank_window`

## Requirements
- R1: A banked access translates to physical byte address {bank[BANK_W-1:0], offset[WIN_AW-1:0]}. Aperture 0 decodes host addresses from WIN0_BASE (default 0x0A8000) and aperture 1 from WIN1_BASE (default 0x0B0000), each 2^WIN_AW bytes long (default 128). Aperture 0 uses bank0_sel and aperture 1 uses bank1_sel, and selector bits above BANK_W (default 4) are ignored.
- R2: A host address whose bits above MEM_AW equal those of FLAT_BASE (default 0xF00000) reaches physical byte address req_addr[MEM_AW-1:0] (MEM_AW = WIN_AW + BANK_W, default 11) with no bank applied.
- R3: req_size 0 is a byte access on data bits 7:0 and req_size 1 is a word access. A word places bits 7:0 at the physical address and bits 15:8 at that address plus one, wrapping modulo the memory size.
- R4: Every read request gets rd_valid exactly one clock later. A read with req_size 2 or 3, or a read that hits no aperture, returns 0. Writes of that kind change neither the memory nor the dirty state.
- R5: A memory write byte at physical address P ORs a flag into dirty entry P[MEM_AW-2:3]. The flag is 2'b10 when P[MEM_AW-1] is 1 and 2'b01 otherwise. A word write marks the entries of both of its bytes.
- R6: gfx_changed is the sticky OR of every flag marked since the last clear or reset.
- R7: When plane_enable is 1 and mode_bits[0] is 1, a byte read of a banked aperture returns 0 and a byte write to it changes neither the memory, the bitmap nor gfx_changed. No other mode bit has this effect.
- R8: In that mode, a banked word access drives pl_valid in the same cycle, together with pl_write, pl_win (aperture number), pl_offset and pl_wdata, and leaves the memory untouched. A word read returns the pl_rdata value sampled in the request cycle, one clock later.
- R9: The flat aperture reads and writes the memory normally while plane mode is active.
- R10: scan_req with scan_idx returns that entry's value before this cycle's update on scan_flags with scan_valid one clock later, and clears the entry. A mark from a write in the same cycle survives the clear.
- R11: dirty_clr zeroes every bitmap entry and gfx_changed. Marks from a write in the same cycle survive the clear.
- R12: After reset rd_valid, scan_valid, gfx_changed and every bitmap entry are 0, and pl_valid is 0 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, others invalid |
| req_addr | input | HOST_AW | Host byte address |
| req_wdata | input | 16 | Write data, little-endian |
| rd_valid | output | 1 | Read data valid, one clock after a read request |
| rd_data | output | 16 | Read data |
| bank0_sel | input | BANK_REG_W | Bank selector of aperture 0 |
| bank1_sel | input | BANK_REG_W | Bank selector of aperture 1 |
| plane_enable | input | 1 | Graphics enable qualifying plane mode |
| mode_bits | input | 8 | Mode byte, bit 0 selects plane access |
| pl_valid | output | 1 | Forwarded plane word access |
| pl_write | output | 1 | Forwarded access is a write |
| pl_win | output | 1 | Aperture of the forwarded access |
| pl_offset | output | WIN_AW | Aperture-relative byte offset |
| pl_wdata | output | 16 | Forwarded write data |
| pl_rdata | input | 16 | Plane engine read reply, same cycle |
| dirty_clr | input | 1 | Clear bitmap and summary |
| scan_req | input | 1 | Fetch and clear one dirty entry |
| scan_idx | input | MEM_AW-4 | Entry to fetch |
| scan_valid | output | 1 | scan_flags valid |
| scan_flags | output | 2 | Fetched entry: bit 0 lower half, bit 1 upper half |
| gfx_changed | output | 2 | Sticky summary of marked flags |

## Verification
Writes go in through one aperture and come back through another, so an error in the bank concatenation cannot hide behind a matching error on the read side. A selector with high bits set shows whether those bits are masked. Word writes are aimed at a group boundary and at the last byte of the memory, which exposes a missing second mark and a missing wrap. Physical addresses in the two halves of the memory that share a dirty entry show whether the half flag is chosen correctly. The plane-mode sequence pairs each gated banked access with a flat read of the same byte, and it toggles single mode bits, which separates dropping from forwarding and checks that the flat aperture does not depend on the mode.

// File: rtl/vbw_pkg.sv
// Shared constants and types of the banked video memory window.
// Assumes a 16-bit host data path carried as two byte lanes.
package vbw_pkg;
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    // Source of the data returned one cycle after a read request.
    typedef enum logic [1:0] {
        RSRC_NONE  = 2'd0,
        RSRC_MEM   = 2'd1,
        RSRC_PLANE = 2'd2
    } rd_src_e;

    typedef logic [1:0] half_flag_t;
endpackage

// File: rtl/vbw_decode.sv
// Request decoder: matches the host address against the two banked apertures
// and the flat aperture, forms the physical byte addresses of both lanes and
// decides whether the access goes to memory, to the plane port or nowhere.
// Assumes the three apertures do not overlap. Purely combinational.
module vbw_decode #(
    parameter int HOST_AW    = 24,
    parameter int WIN_AW     = 7,
    parameter int BANK_W     = 4,
    parameter int BANK_REG_W = 8,
    parameter logic [HOST_AW-1:0] WIN0_BASE = 24'h0A8000,
    parameter logic [HOST_AW-1:0] WIN1_BASE = 24'h0B0000,
    parameter logic [HOST_AW-1:0] FLAT_BASE = 24'hF00000,
    localparam int MEM_AW = WIN_AW + BANK_W
) (
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [HOST_AW-1:0]    req_addr,
    input  logic [BANK_REG_W-1:0] bank0_sel,
    input  logic [BANK_REG_W-1:0] bank1_sel,
    input  logic                  plane_enable,
    input  logic                  plane_bit,
    output logic                  is_word,
    output logic                  gated,
    output logic                  win_sel,
    output logic                  fwd,
    output logic                  mem_rd,
    output logic                  we_lo,
    output logic                  we_hi,
    output logic [MEM_AW-1:0]     phys_lo,
    output logic [MEM_AW-1:0]     phys_hi
);
    import vbw_pkg::*;

    logic [1:0]                      hit_win;
    logic [1:0][BANK_REG_W-1:0]      bank_of;
    logic                            hit_flat;
    logic                            banked;
    logic                            size_ok;
    logic                            mem_act;
    logic [BANK_W-1:0]               bank_now;

    assign bank_of[0] = bank0_sel;
    assign bank_of[1] = bank1_sel;

    // One comparator per banked aperture.
    for (genvar w = 0; w < 2; w++) begin : g_win
        localparam logic [HOST_AW-1:0] BASE = (w == 0) ? WIN0_BASE : WIN1_BASE;
        assign hit_win[w] = (req_addr[HOST_AW-1:WIN_AW] == BASE[HOST_AW-1:WIN_AW]);
    end

    // Aperture hit, size legality and plane-mode gating.
    always_comb begin
        hit_flat = (req_addr[HOST_AW-1:MEM_AW] == FLAT_BASE[HOST_AW-1:MEM_AW]);
        banked   = |hit_win;
        win_sel  = ~hit_win[0] & hit_win[1];
        size_ok  = (req_size == SZ_BYTE) || (req_size == SZ_WORD);
        is_word  = (req_size == SZ_WORD);
        gated    = banked & plane_enable & plane_bit;
        fwd      = req_valid & size_ok & gated & is_word;
        mem_act  = req_valid & size_ok & (banked | hit_flat) & ~gated;
        we_lo    = mem_act & req_write;
        we_hi    = we_lo & is_word;
        mem_rd   = mem_act & ~req_write;
    end

    // Physical byte address of each lane.
    always_comb begin
        bank_now = bank_of[win_sel][BANK_W-1:0];
        phys_lo  = banked ? {bank_now, req_addr[WIN_AW-1:0]} : req_addr[MEM_AW-1:0];
        phys_hi  = phys_lo + MEM_AW'(1);
    end

    logic unused_bank_hi;
    assign unused_bank_hi = ^{bank0_sel, bank1_sel};
endmodule

// File: rtl/vbw_store.sv
// Byte-wide video memory with two lanes, so that a word access reads or writes
// both of its bytes in one cycle. Registered read, no reset on the array.
// Assumes the two lane addresses differ whenever both write enables are set.
module vbw_store #(
    parameter int MEM_AW = 11,
    localparam int DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic              re,
    input  logic [MEM_AW-1:0] a_lo,
    input  logic [MEM_AW-1:0] a_hi,
    input  logic [7:0]        d_lo,
    input  logic [7:0]        d_hi,
    output logic [7:0]        q_lo,
    output logic [7:0]        q_hi
);
    logic [7:0] mem [DEPTH];

    // Lane writes and registered lane reads.
    always_ff @(posedge clk) begin
        if (we_lo) mem[a_lo] <= d_lo;
        if (we_hi) mem[a_hi] <= d_hi;
        if (re) begin
            q_lo <= mem[a_lo];
            q_hi <= mem[a_hi];
        end
    end
endmodule

// File: rtl/vbw_dirty.sv
// Dirty bitmap of 8-byte groups with a half-select flag per entry, a sticky
// summary and a fetch-and-clear scan port. Up to two marks per cycle.
// Assumes marks are applied after clears in the same cycle.
module vbw_dirty #(
    parameter int MEM_AW = 11,
    localparam int IW  = MEM_AW - 4,
    localparam int ENT = 1 << IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mk_a,
    input  logic [MEM_AW-1:0] a_addr,
    input  logic              mk_b,
    input  logic [MEM_AW-1:0] b_addr,
    input  logic              scan_req,
    input  logic [IW-1:0]     scan_idx,
    output logic              scan_valid,
    output logic [1:0]        scan_flags,
    output logic [1:0]        summary
);
    import vbw_pkg::*;

    half_flag_t          ent     [ENT];
    half_flag_t          ent_nxt [ENT];
    logic [IW-1:0]       idx_a, idx_b;
    half_flag_t          fl_a, fl_b;
    half_flag_t          sum_nxt;

    // Entry index and half flag of each marked byte.
    always_comb begin
        idx_a = a_addr[MEM_AW-2:3];
        idx_b = b_addr[MEM_AW-2:3];
        fl_a  = a_addr[MEM_AW-1] ? 2'b10 : 2'b01;
        fl_b  = b_addr[MEM_AW-1] ? 2'b10 : 2'b01;
    end

    // Next bitmap: clear or scan first, then OR the marks.
    always_comb begin
        for (int i = 0; i < ENT; i++) begin
            ent_nxt[i] = (clr || (scan_req && scan_idx == IW'(i))) ? 2'b00 : ent[i];
            if (mk_a && idx_a == IW'(i)) ent_nxt[i] = ent_nxt[i] | fl_a;
            if (mk_b && idx_b == IW'(i)) ent_nxt[i] = ent_nxt[i] | fl_b;
        end
        sum_nxt = (clr ? 2'b00 : summary) | (mk_a ? fl_a : 2'b00) | (mk_b ? fl_b : 2'b00);
    end

    // Bitmap, summary and scan result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT; i++) ent[i] <= 2'b00;
            summary    <= 2'b00;
            scan_valid <= 1'b0;
            scan_flags <= 2'b00;
        end else begin
            for (int i = 0; i < ENT; i++) ent[i] <= ent_nxt[i];
            summary    <= sum_nxt;
            scan_valid <= scan_req;
            scan_flags <= scan_req ? ent[scan_idx] : 2'b00;
        end
    end

    // R6
    sum_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((summary & $past(summary)) == $past(summary)));

    // R5
    mark_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mk_a |=> ((summary & $past(fl_a)) != 2'b00));

    // R10
    scan_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> scan_valid);

    logic unused_low;
    assign unused_low = ^{a_addr[2:0], b_addr[2:0]};
endmodule

// File: rtl/vram_bank_window.sv
// Top of the banked packed-pixel video memory window: decoder, byte memory,
// dirty tracker and the one-cycle read return path with plane forwarding.
// Assumes one host request per cycle and a same-cycle plane read reply.
module vram_bank_window #(
    parameter int HOST_AW    = 24,
    parameter int WIN_AW     = 7,
    parameter int BANK_W     = 4,
    parameter int BANK_REG_W = 8,
    parameter logic [HOST_AW-1:0] WIN0_BASE = 24'h0A8000,
    parameter logic [HOST_AW-1:0] WIN1_BASE = 24'h0B0000,
    parameter logic [HOST_AW-1:0] FLAT_BASE = 24'hF00000,
    localparam int MEM_AW = WIN_AW + BANK_W,
    localparam int IW     = MEM_AW - 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [HOST_AW-1:0]    req_addr,
    input  logic [15:0]           req_wdata,
    output logic                  rd_valid,
    output logic [15:0]           rd_data,
    input  logic [BANK_REG_W-1:0] bank0_sel,
    input  logic [BANK_REG_W-1:0] bank1_sel,
    input  logic                  plane_enable,
    input  logic [7:0]            mode_bits,
    output logic                  pl_valid,
    output logic                  pl_write,
    output logic                  pl_win,
    output logic [WIN_AW-1:0]     pl_offset,
    output logic [15:0]           pl_wdata,
    input  logic [15:0]           pl_rdata,
    input  logic                  dirty_clr,
    input  logic                  scan_req,
    input  logic [IW-1:0]         scan_idx,
    output logic                  scan_valid,
    output logic [1:0]            scan_flags,
    output logic [1:0]            gfx_changed
);
    import vbw_pkg::*;

    logic              is_word, gated, win_sel, fwd, mem_rd, we_lo, we_hi;
    logic [MEM_AW-1:0] phys_lo, phys_hi;
    logic [7:0]        q_lo, q_hi;
    rd_src_e           rd_src;
    logic              rd_word;
    logic [15:0]       pl_q;

    vbw_decode #(
        .HOST_AW(HOST_AW), .WIN_AW(WIN_AW), .BANK_W(BANK_W), .BANK_REG_W(BANK_REG_W),
        .WIN0_BASE(WIN0_BASE), .WIN1_BASE(WIN1_BASE), .FLAT_BASE(FLAT_BASE)
    ) u_decode (
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .bank0_sel(bank0_sel), .bank1_sel(bank1_sel),
        .plane_enable(plane_enable), .plane_bit(mode_bits[0]),
        .is_word(is_word), .gated(gated), .win_sel(win_sel), .fwd(fwd),
        .mem_rd(mem_rd), .we_lo(we_lo), .we_hi(we_hi),
        .phys_lo(phys_lo), .phys_hi(phys_hi)
    );

    vbw_store #(.MEM_AW(MEM_AW)) u_store (
        .clk(clk), .we_lo(we_lo), .we_hi(we_hi), .re(mem_rd),
        .a_lo(phys_lo), .a_hi(phys_hi),
        .d_lo(req_wdata[7:0]), .d_hi(req_wdata[15:8]),
        .q_lo(q_lo), .q_hi(q_hi)
    );

    vbw_dirty #(.MEM_AW(MEM_AW)) u_dirty (
        .clk(clk), .rst_n(rst_n), .clr(dirty_clr),
        .mk_a(we_lo), .a_addr(phys_lo), .mk_b(we_hi), .b_addr(phys_hi),
        .scan_req(scan_req), .scan_idx(scan_idx),
        .scan_valid(scan_valid), .scan_flags(scan_flags), .summary(gfx_changed)
    );

    // Plane port is a direct view of the request when it is forwarded.
    always_comb begin
        pl_valid  = fwd;
        pl_write  = req_write;
        pl_win    = win_sel;
        pl_offset = req_addr[WIN_AW-1:0];
        pl_wdata  = req_wdata;
    end

    // Remember where the read data of this cycle's request comes from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_src   <= RSRC_NONE;
            rd_word  <= 1'b0;
            pl_q     <= 16'h0;
        end else begin
            rd_valid <= req_valid & ~req_write;
            rd_src   <= (fwd && !req_write) ? RSRC_PLANE : (mem_rd ? RSRC_MEM : RSRC_NONE);
            rd_word  <= is_word;
            pl_q     <= pl_rdata;
        end
    end

    // Read data mux.
    always_comb begin
        case (rd_src)
            RSRC_MEM:   rd_data = rd_word ? {q_hi, q_lo} : {8'h00, q_lo};
            RSRC_PLANE: rd_data = pl_q;
            default:    rd_data = 16'h0;
        endcase
    end

    // R4
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R7
    plane_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == SZ_BYTE && gated) |=> (rd_valid && rd_data == 16'h0));

    // R8
    plane_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_valid && !pl_write) |=> (rd_data == $past(pl_rdata)));

    // R12
    idle_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !pl_valid);

    logic unused_mode;
    assign unused_mode = ^mode_bits[7:1];
endmodule

// File: tb/vram_bank_window_bench.sv
// Scoreboard bench: the driver task models each request and queues the
// expected read and scan results; a monitor pops and compares them.
module vram_bank_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [23:0] req_addr = 24'h0;
    logic [15:0] req_wdata = 16'h0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [7:0]  bank0_sel = 8'h0, bank1_sel = 8'h0;
    logic        plane_enable = 1'b0;
    logic [7:0]  mode_bits = 8'h0;
    logic        pl_valid, pl_write, pl_win;
    logic [6:0]  pl_offset;
    logic [15:0] pl_wdata;
    logic [15:0] pl_rdata = 16'h0;
    logic        dirty_clr = 1'b0, scan_req = 1'b0;
    logic [6:0]  scan_idx = 7'h0;
    logic        scan_valid;
    logic [1:0]  scan_flags, gfx_changed;

    int n_chk = 0, n_bad = 0;
    logic [7:0]  ref_mem   [2048];
    logic [1:0]  ref_dirty [128];
    logic [1:0]  ref_sum = 2'b00;
    logic [15:0] rd_q[$];
    string       rd_tag[$];
    logic [1:0]  sc_q[$];
    string       sc_tag[$];

    always #10 clk = ~clk;

    vram_bank_window u_vram_bank_window (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .bank0_sel(bank0_sel),
        .bank1_sel(bank1_sel), .plane_enable(plane_enable), .mode_bits(mode_bits),
        .pl_valid(pl_valid), .pl_write(pl_write), .pl_win(pl_win),
        .pl_offset(pl_offset), .pl_wdata(pl_wdata), .pl_rdata(pl_rdata),
        .dirty_clr(dirty_clr), .scan_req(scan_req), .scan_idx(scan_idx),
        .scan_valid(scan_valid), .scan_flags(scan_flags), .gfx_changed(gfx_changed)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mark(input logic [10:0] p);
        ref_dirty[p[9:3]] = ref_dirty[p[9:3]] | (p[10] ? 2'b10 : 2'b01);
        ref_sum = ref_sum | (p[10] ? 2'b10 : 2'b01);
    endtask

    // One cycle of stimulus, called at a falling edge; updates the model.
    task automatic drive(input logic v, input logic w, input logic [1:0] sz, input logic [23:0] a,
                         input logic [15:0] d, input logic s, input logic [6:0] si,
                         input logic c, input string tag);
        int kind; logic win; logic [10:0] ph; logic [15:0] exp; bit fw;
        req_valid = v; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
        pl_rdata = d; scan_req = s; scan_idx = si; dirty_clr = c;
        if (s) begin sc_q.push_back(ref_dirty[si]); sc_tag.push_back(tag); end
        if (c) begin
            for (int i = 0; i < 128; i++) ref_dirty[i] = 2'b00;
            ref_sum = 2'b00;
        end
        if (s) ref_dirty[si] = 2'b00;
        kind = 0; win = 1'b0; ph = 11'h0; exp = 16'h0; fw = 1'b0;
        if ((a >> 7) == (24'h0A8000 >> 7)) begin kind = 1; ph = {bank0_sel[3:0], a[6:0]}; end
        else if ((a >> 7) == (24'h0B0000 >> 7)) begin kind = 1; win = 1'b1; ph = {bank1_sel[3:0], a[6:0]}; end
        else if ((a >> 11) == (24'hF00000 >> 11)) begin kind = 2; ph = a[10:0]; end
        if (v && sz < 2 && kind != 0) begin
            if (kind == 1 && plane_enable && mode_bits[0]) begin
                if (sz == 2'd1) begin fw = 1'b1; exp = d; end
            end else if (w) begin
                ref_mem[ph] = d[7:0]; mark(ph);
                if (sz == 2'd1) begin ref_mem[ph + 11'd1] = d[15:8]; mark(ph + 11'd1); end
            end else begin
                exp = (sz == 2'd1) ? {ref_mem[ph + 11'd1], ref_mem[ph]} : {8'h00, ref_mem[ph]};
            end
        end
        if (v && !w) begin rd_q.push_back(exp); rd_tag.push_back(tag); end
        #1;
        if (v) begin
            if (fw)
                check(pl_valid && pl_write == w && pl_win == win && pl_offset == a[6:0]
                      && (!w || pl_wdata == d), {tag, " plane port"}, pl_wdata, d);
            else
                check(!pl_valid, {tag, " no plane forward"}, {15'h0, pl_valid}, 16'h0);
        end
        @(negedge clk);
        req_valid = 1'b0; scan_req = 1'b0; dirty_clr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sz, input logic [23:0] a, input logic [15:0] d, input string tag);
        drive(1'b1, 1'b1, sz, a, d, 1'b0, 7'h0, 1'b0, tag);
    endtask
    task automatic rd(input logic [1:0] sz, input logic [23:0] a, input logic [15:0] reply, input string tag);
        drive(1'b1, 1'b0, sz, a, reply, 1'b0, 7'h0, 1'b0, tag);
    endtask
    task automatic scan(input logic [6:0] idx, input string tag);
        drive(1'b0, 1'b0, 2'd0, 24'h0, 16'h0, 1'b1, idx, 1'b0, tag);
    endtask
    task automatic chk_sum(input string tag);
        check(gfx_changed == ref_sum, {tag, " summary"}, {14'h0, gfx_changed}, {14'h0, ref_sum});
    endtask

    // Monitor: compare results against the queued expectations.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (rd_q.size() == 0) check(1'b0, "R4 unexpected rd_valid", 16'h1, 16'h0);
            else begin
                logic [15:0] e; string t;
                e = rd_q.pop_front(); t = rd_tag.pop_front();
                check(rd_data === e, {t, " read data"}, rd_data, e);
            end
        end
        if (rst_n && scan_valid) begin
            if (sc_q.size() == 0) check(1'b0, "R10 unexpected scan_valid", 16'h1, 16'h0);
            else begin
                logic [1:0] e; string t;
                e = sc_q.pop_front(); t = sc_tag.pop_front();
                check(scan_flags === e, {t, " scan flags"}, {14'h0, scan_flags}, {14'h0, e});
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        check(1'b0, "watchdog expired", 16'h0, 16'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 128; i++) ref_dirty[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(!rd_valid && !scan_valid && !pl_valid && gfx_changed == 2'b00,
              "R12 reset outputs", {rd_valid, scan_valid, pl_valid, 11'h0, gfx_changed}, 16'h0);
        scan(7'h05, "R12");

        bank0_sel = 8'h03; bank1_sel = 8'h0C;
        wr(2'd0, 24'hF00010, 16'h005A, "R2");
        rd(2'd0, 24'hF00010, 16'h0, "R2");
        wr(2'd0, 24'h0A8005, 16'h0011, "R1");
        rd(2'd0, 24'hF00185, 16'h0, "R1");
        bank0_sel = 8'hF3;
        rd(2'd0, 24'h0A8005, 16'h0, "R1");
        wr(2'd1, 24'h0B0010, 16'hBEEF, "R3");
        rd(2'd0, 24'hF00611, 16'h0, "R3");
        rd(2'd1, 24'h0B0010, 16'h0, "R3");
        wr(2'd0, 24'hF00210, 16'h0022, "R5");
        scan(7'h42, "R5");
        scan(7'h42, "R10");
        wr(2'd1, 24'hF00017, 16'hA1B2, "R5");
        scan(7'h03, "R5");
        scan(7'h02, "R5");
        wr(2'd1, 24'hF007FF, 16'hC3D4, "R3");
        rd(2'd0, 24'hF00000, 16'h0, "R3");
        rd(2'd0, 24'hF007FF, 16'h0, "R3");
        chk_sum("R6");

        drive(1'b0, 1'b0, 2'd0, 24'h0, 16'h0, 1'b0, 7'h0, 1'b1, "R11");
        chk_sum("R11");
        scan(7'h00, "R11");
        drive(1'b1, 1'b1, 2'd0, 24'hF00100, 16'h0066, 1'b0, 7'h0, 1'b1, "R11");
        chk_sum("R11");
        scan(7'h20, "R11");

        rd(2'd2, 24'hF00010, 16'h0, "R4");
        wr(2'd3, 24'hF00185, 16'h00EE, "R4");
        rd(2'd0, 24'hF00185, 16'h0, "R4");
        rd(2'd0, 24'h000000, 16'h0, "R4");
        chk_sum("R4");

        plane_enable = 1'b1; mode_bits = 8'h01;
        wr(2'd0, 24'h0A8005, 16'h0099, "R7");
        chk_sum("R7");
        scan(7'h30, "R7");
        rd(2'd0, 24'h0A8005, 16'h0, "R7");
        rd(2'd0, 24'hF00185, 16'h0, "R7");
        wr(2'd1, 24'h0B0020, 16'h1234, "R8");
        rd(2'd1, 24'h0A8004, 16'hCAFE, "R8");
        wr(2'd1, 24'h0B0010, 16'h5555, "R8");
        rd(2'd1, 24'hF00610, 16'h0, "R8");
        chk_sum("R8");
        wr(2'd0, 24'hF00300, 16'h0077, "R9");
        rd(2'd0, 24'hF00300, 16'h0, "R9");
        mode_bits = 8'hFE;
        rd(2'd0, 24'h0A8005, 16'h0, "R7");
        plane_enable = 1'b0; mode_bits = 8'h01;
        rd(2'd0, 24'h0A8005, 16'h0, "R7");

        drive(1'b1, 1'b1, 2'd0, 24'hF00400, 16'h0088, 1'b1, 7'h00, 1'b0, "R10");
        scan(7'h00, "R10");
        chk_sum("R10");

        repeat (3) @(negedge clk);
        check(rd_q.size() == 0 && sc_q.size() == 0, "R4 pending results",
              16'(rd_q.size() + sc_q.size()), 16'h0);
        finish_run();
    end
endmodule